// File: doc/BRIEF.md
# Serial ADC Power-Sequencing Master

This block is a host-side serial master for a 14-bit successive-approximation converter that has a single select line. It takes commands over a valid/ready port and turns each one into a select/clock frame. A plain conversion runs a full frame and returns the captured sample. A sleep command ends its frame early, on a chosen serial clock count. The converter reads that early end as a request to power down its analog section. A wake command runs a complete frame so that the converter powers up again, and the data from that frame is dropped.

The controller keeps a flag that records whether the converter is awake. If a conversion is requested while the converter is asleep, the `auto_wake` input decides what happens. When it is clear, the request is accepted and dropped. When it is set, a wake frame is inserted, and the requested conversion then follows on its own. The serial clock is derived from the system clock by a divider that is set at run time. Between frames the select line stays high for at least one full serial clock period.

Top module: `adc_pwr_seq_ctrl`

## Requirements
- R1: Out of reset `adc_cs_n`=1, `adc_sclk`=1, `cmd_ready`=1, `res_valid`=0 and `powered_up`=1. Whenever select is high, the serial clock is high.
- R2: Each serial clock half period lasts `div_half`+1 system clock cycles.
- R3: Opcode 0 (convert) while `powered_up`=1 gives one frame with exactly 16 serial clock falling edges. The line is sampled at each falling edge. The sample from edge k goes to result bit 16-k for k=3..16, most significant bit first. The samples from edges 1 and 2 are ignored.
- R4: Opcode 1 (sleep) raises select after the 4th falling edge and before a 5th. It clears `powered_up` and produces no result.
- R5: Opcode 2 (wake) runs a frame with 16 falling edges. It sets `powered_up` and produces no result.
- R6: Opcode 0 while `powered_up`=0 and `auto_wake`=0 is accepted but starts no frame and produces no result.
- R7: Opcode 0 while `powered_up`=0 and `auto_wake`=1 runs a wake frame and then a conversion frame. It produces exactly one result, and that result holds the second frame's data.
- R8: Between two consecutive frames, select stays high for at least 2×(`div_half`+1) system clock cycles.
- R9: `cmd_ready` is high only while no frame or gap is in progress. Opcode 3 is accepted and has no effect.
- R10: `res_valid` is a single-cycle pulse, and `res_data` is valid during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_half | input | 8 | Serial clock half period in system cycles, minus one |
| auto_wake | input | 1 | Insert a wake frame before a convert issued while asleep |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 convert, 1 sleep, 2 wake, 3 no-op |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_sdata | input | 1 | Serial data from the converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 14 | Conversion result |
| powered_up | output | 1 | Controller's view of the converter power state |

## Verification
The hardest situation to reach is the back-to-back pair of frames inside a single command. This pair, a dummy wake frame followed by the real conversion with an inter-frame gap between them, exists only when the converter is asleep and `auto_wake` is set. The stimulus first puts the converter to sleep with opcode 1 and then issues a convert with `auto_wake` high. The bench counts the frames and the falling edges, measures how long select stays high between the two frames, and checks that only the second frame's word appears as a result. The model converter drives different leading bits in each test, which shows that those bits are dropped.

// File: rtl/adc_pss_pkg.sv
package adc_pss_pkg;

  typedef enum logic [1:0] {
    OP_CONV  = 2'd0,
    OP_SLEEP = 2'd1,
    OP_WAKE  = 2'd2,
    OP_NOP   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    FR_CONV  = 2'd0,
    FR_SLEEP = 2'd1,
    FR_WAKE  = 2'd2
  } frame_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_GAP   = 2'd2
  } state_e;

  // Number of falling edges after which a frame of the given kind closes.
  function automatic int unsigned frame_edges(frame_e kind, int unsigned full_len,
                                               int unsigned sleep_edge);
    return (kind == FR_SLEEP) ? sleep_edge : full_len;
  endfunction

endpackage

// File: rtl/adc_pss_tick.sv
module adc_pss_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt >= div_half);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_pss_capture.sv
module adc_pss_capture #(
  parameter int RES_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             din,
  output logic [RES_W-1:0] word
);
  // Leading bits are shifted out of the top and lost.
  always_ff @(posedge clk) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[RES_W-2:0], din};
  end
endmodule

// File: rtl/adc_pwr_seq_ctrl.sv
module adc_pwr_seq_ctrl
  import adc_pss_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int RES_W      = 14,
  parameter int FRAME_LEN  = 16,
  parameter int SLEEP_EDGE = 4,
  parameter int GAP_HALVES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_half,
  input  logic             auto_wake,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  output logic             cmd_ready,
  output logic             adc_cs_n,
  output logic             adc_sclk,
  input  logic             adc_sdata,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data,
  output logic             powered_up
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam int GAP_W = (GAP_HALVES > 1) ? $clog2(GAP_HALVES) : 1;

  state_e           st;
  frame_e           kind;
  logic             pend_conv;
  logic [CNT_W-1:0] falls;
  logic [GAP_W-1:0] gap_cnt;
  logic             cs_q, sclk_q, pwr_q, rv_q;
  logic [RES_W-1:0] res_q;
  logic [RES_W-1:0] cap_word;

  // Named internal events, also used by the checker.
  logic   tick, accept, last_edge, fall_evt, frame_end, gap_done;
  logic   go;
  frame_e go_kind;
  logic   go_pend;

  adc_pss_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(st != ST_IDLE), .div_half(div_half), .tick(tick)
  );

  adc_pss_capture #(.RES_W(RES_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .shift_en(fall_evt), .din(adc_sdata), .word(cap_word)
  );

  assign accept    = cmd_valid && (st == ST_IDLE);
  assign last_edge = (32'(falls) == frame_edges(kind, FRAME_LEN, SLEEP_EDGE));
  assign fall_evt  = (st == ST_FRAME) && tick && sclk_q && !last_edge;
  assign frame_end = (st == ST_FRAME) && tick && sclk_q && last_edge;
  assign gap_done  = (st == ST_GAP) && tick && (gap_cnt == GAP_W'(GAP_HALVES - 1));

  always_comb begin
    go      = 1'b0;
    go_kind = FR_CONV;
    go_pend = 1'b0;
    if (accept) begin
      case (op_e'(cmd_op))
        OP_CONV: begin
          if (pwr_q) begin
            go = 1'b1;
          end else if (auto_wake) begin
            go      = 1'b1;
            go_kind = FR_WAKE;
            go_pend = 1'b1;
          end
        end
        OP_SLEEP: begin go = 1'b1; go_kind = FR_SLEEP; end
        OP_WAKE:  begin go = 1'b1; go_kind = FR_WAKE;  end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      kind      <= FR_CONV;
      pend_conv <= 1'b0;
      falls     <= '0;
      gap_cnt   <= '0;
      cs_q      <= 1'b1;
      sclk_q    <= 1'b1;
      pwr_q     <= 1'b1;
      rv_q      <= 1'b0;
      res_q     <= '0;
    end else begin
      rv_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (go) begin
            st        <= ST_FRAME;
            cs_q      <= 1'b0;
            falls     <= '0;
            kind      <= go_kind;
            pend_conv <= go_pend;
          end
        end
        ST_FRAME: begin
          if (tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
            end else if (last_edge) begin
              cs_q    <= 1'b1;
              st      <= ST_GAP;
              gap_cnt <= '0;
              case (kind)
                FR_CONV:  begin rv_q <= 1'b1; res_q <= cap_word; end
                FR_SLEEP: pwr_q <= 1'b0;
                default:  pwr_q <= 1'b1;
              endcase
            end else begin
              sclk_q <= 1'b0;
              falls  <= falls + 1'b1;
            end
          end
        end
        default: begin
          if (gap_done) begin
            if (pend_conv) begin
              st        <= ST_FRAME;
              cs_q      <= 1'b0;
              falls     <= '0;
              kind      <= FR_CONV;
              pend_conv <= 1'b0;
            end else begin
              st <= ST_IDLE;
            end
          end else if (tick) begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign cmd_ready  = (st == ST_IDLE);
  assign adc_cs_n   = cs_q;
  assign adc_sclk   = sclk_q;
  assign res_valid  = rv_q;
  assign res_data   = res_q;
  assign powered_up = pwr_q;
endmodule

// File: rtl/adc_pss_checker.sv
module adc_pss_checker #(
  parameter int FRAME_LEN = 16,
  parameter int CNT_W     = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sclk,
  input logic             ready,
  input logic             rvalid,
  input logic             pwr,
  input logic             tick,
  input logic             fall_evt,
  input logic [CNT_W-1:0] falls
);
  // R1: serial clock parked high whenever select is high
  a_r1_sclk_high_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  // R2: serial clock only moves after a divider tick
  a_r2_sclk_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sclk));

  // R3: a frame never goes past its full edge count
  a_r3_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |-> (32'(falls) < FRAME_LEN));

  // R3: a result appears exactly as a frame closes
  a_r3_result_at_frame_close: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $rose(cs_n));

  // R4: power state drops only as a frame closes
  a_r4_sleep_at_frame_close: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr) |-> $rose(cs_n));

  // R7: no result is produced while marked asleep
  a_r7_result_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> pwr);

  // R9: ready only while the bus is idle
  a_r9_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> cs_n);

  // R10: result strobe lasts one cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);
endmodule

bind adc_pwr_seq_ctrl adc_pss_checker #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(adc_cs_n), .sclk(adc_sclk), .ready(cmd_ready),
  .rvalid(res_valid), .pwr(powered_up), .tick(tick), .fall_evt(fall_evt), .falls(falls)
);

// File: tb/adc_pwr_seq_ctrl_test.sv
module adc_pwr_seq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  div_half = 8'd2;
  logic        auto_wake = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic        cmd_ready, adc_cs_n, adc_sclk, res_valid, powered_up;
  logic        adc_sdata = 1'b0;
  logic [13:0] res_data;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #10 clk = ~clk;

  adc_pwr_seq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .div_half(div_half), .auto_wake(auto_wake),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ready(cmd_ready),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_sdata(adc_sdata),
    .res_valid(res_valid), .res_data(res_data), .powered_up(powered_up)
  );

  // Converter model and bus monitors
  logic [15:0] adc_word = 16'h0;
  int bit_idx = 15;
  int frames, falls, results, pulse_max, pulse_run, min_gap, min_half, max_half;
  int gap_run, half_run, edges_in_frame;
  logic [13:0] last_res;
  logic prev_sclk = 1'b1;

  always @(negedge adc_cs_n) begin
    frames++;
    bit_idx = 15;
    adc_sdata = adc_word[15];
  end

  always @(negedge adc_sclk) begin
    if (!adc_cs_n) begin
      falls++;
      bit_idx--;
      if (bit_idx >= 0) adc_sdata = adc_word[bit_idx];
    end
  end

  always @(negedge clk) begin
    if (res_valid) begin results++; last_res = res_data; pulse_run++; end
    else pulse_run = 0;
    if (pulse_run > pulse_max) pulse_max = pulse_run;
    if (adc_cs_n) gap_run++;
    else begin
      if (gap_run > 0 && frames >= 2 && gap_run < min_gap) min_gap = gap_run;
      gap_run = 0;
    end
    if (adc_sclk !== prev_sclk) begin
      if (!adc_cs_n && edges_in_frame > 0) begin
        if (half_run < min_half) min_half = half_run;
        if (half_run > max_half) max_half = half_run;
      end
      edges_in_frame = adc_cs_n ? 0 : edges_in_frame + 1;
      half_run = 1;
    end else begin
      half_run++;
      if (adc_cs_n) edges_in_frame = 0;
    end
    prev_sclk = adc_sclk;
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_stats();
    frames = 0; falls = 0; results = 0; pulse_max = 0; last_res = '0;
    min_gap = 1 << 30; min_half = 1 << 30; max_half = 0; gap_run = 0;
  endtask

  task automatic run_cmd(logic [1:0] op, logic aw);
    @(negedge clk); #1;
    clear_stats();
    auto_wake = aw; cmd_op = op; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!cmd_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic        aw;
    logic [15:0] word;
    logic [7:0]  n_res;
    logic [13:0] data;
    logic [7:0]  n_frames;
    logic [7:0]  n_falls;
    logic        pwr;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{2'd0, 1'b0, 16'hD234, 8'd1, 14'h1234, 8'd1, 8'd16, 1'b1}, // R3 convert
    '{2'd1, 1'b0, 16'h0000, 8'd0, 14'h0000, 8'd1, 8'd4,  1'b0}, // R4 sleep
    '{2'd0, 1'b0, 16'h1111, 8'd0, 14'h0000, 8'd0, 8'd0,  1'b0}, // R6 dropped
    '{2'd2, 1'b0, 16'h3FFF, 8'd0, 14'h0000, 8'd1, 8'd16, 1'b1}, // R5 wake
    '{2'd0, 1'b0, 16'hC000, 8'd1, 14'h0000, 8'd1, 8'd16, 1'b1}, // R3 leading ones dropped
    '{2'd1, 1'b0, 16'hFFFF, 8'd0, 14'h0000, 8'd1, 8'd4,  1'b0}, // R4 sleep again
    '{2'd0, 1'b1, 16'h6AAA, 8'd1, 14'h2AAA, 8'd2, 8'd32, 1'b1}, // R7 auto wake
    '{2'd3, 1'b0, 16'h0000, 8'd0, 14'h0000, 8'd0, 8'd0,  1'b1}, // R9 no-op
    '{2'd0, 1'b0, 16'h9555, 8'd1, 14'h1555, 8'd1, 8'd16, 1'b1}  // R3 convert
  };

  initial begin
    clear_stats();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(adc_cs_n === 1'b1 && adc_sclk === 1'b1, "R1", "cs/sclk at reset",
          {adc_cs_n, adc_sclk}, 3);
    check(cmd_ready === 1'b1 && res_valid === 1'b0, "R1", "ready/valid at reset",
          {cmd_ready, res_valid}, 2);
    check(powered_up === 1'b1, "R1", "powered at reset", powered_up, 1);
    rst_n = 1'b1;

    for (int i = 0; i < 9; i++) begin
      adc_word = VEC[i].word;
      run_cmd(VEC[i].op, VEC[i].aw);
      check(results == VEC[i].n_res, "R3", $sformatf("vec %0d result count", i),
            results, VEC[i].n_res);
      if (VEC[i].n_res != 0)
        check(last_res == VEC[i].data, "R3", $sformatf("vec %0d result data", i),
              last_res, VEC[i].data);
      check(frames == VEC[i].n_frames, "R6", $sformatf("vec %0d frames", i),
            frames, VEC[i].n_frames);
      check(falls == VEC[i].n_falls, "R4", $sformatf("vec %0d falling edges", i),
            falls, VEC[i].n_falls);
      check(powered_up == VEC[i].pwr, "R5", $sformatf("vec %0d power flag", i),
            powered_up, VEC[i].pwr);
      if (i == 6)
        check(min_gap >= 6, "R8", "gap between wake and conversion", min_gap, 6);
      if (VEC[i].n_frames != 0) begin
        check(min_half == 3 && max_half == 3, "R2", "half period at div 2", max_half, 3);
        check(pulse_max <= 1, "R10", "result pulse width", pulse_max, 1);
      end
    end

    // R2 divider extremes
    div_half = 8'd0;
    adc_word = 16'h0ABC;
    run_cmd(2'd0, 1'b0);
    check(min_half == 1 && max_half == 1, "R2", "half period at div 0", max_half, 1);
    check(last_res == 14'h0ABC, "R3", "result at fastest clock", last_res, 14'h0ABC);
    div_half = 8'd5;
    run_cmd(2'd1, 1'b0);
    check(min_half == 6 && max_half == 6, "R2", "half period at div 5", max_half, 6);
    // R8 gap at a slow clock via auto wake
    adc_word = 16'h5001;
    run_cmd(2'd0, 1'b1);
    check(min_gap >= 12, "R8", "gap at div 5", min_gap, 12);
    check(results == 1 && last_res == 14'h1001, "R7", "single result after auto wake",
          last_res, 14'h1001);

    // R9 ready low mid-frame
    div_half = 8'd1;
    @(negedge clk); #1;
    cmd_op = 2'd0; auto_wake = 1'b0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (5) @(negedge clk);
    check(cmd_ready === 1'b0 && adc_cs_n === 1'b0, "R9", "ready during frame",
          cmd_ready, 0);
    while (!cmd_ready) @(negedge clk);
    check(adc_cs_n === 1'b1 && adc_sclk === 1'b1, "R1", "idle levels after frame",
          {adc_cs_n, adc_sclk}, 3);

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule